// File: doc/BRIEF.md
# Bus Hold Arbiter

This block sits on the processor side of a shared system bus. It lets an external master, such as a DMA engine, take over that bus. The external master raises `hold_i`. The block first brings the request into its own clock domain. It then waits for any machine cycle the bus unit has in progress to finish, and stops the bus unit from starting a new one. Once the bus is free, it raises `hlda_o`, puts the address, data and strobe drivers into the floating state, and holds the address-latch strobe inactive.

When the external master lowers `hold_i`, the block drops `hlda_o`. It keeps its drivers off for a fixed number of clocks after that, so the two masters never drive the bus at the same time. Only then does it give control back to the bus unit. If the request is withdrawn while the block is still waiting for a cycle to end, the block returns to normal operation without ever raising the acknowledge.

Top module: `bus_hold_arb`

## Requirements
- R1: While `rst_ni` is low, and after it is released with `hold_i` low, `hlda_o`, `bus_float_o`, `ale_block_o` and `stall_o` are all 0.
- R2: `hold_i` passes through `SYNC_STAGES` flip-flops. A level applied before a rising edge has no effect on any output until `SYNC_STAGES` rising edges have sampled it. After those edges, `stall_o` goes to 1.
- R3: When the synchronized request is seen while the bus is idle (`cyc_busy_i` = 0), `hlda_o` rises at the next rising edge.
- R4: When `cyc_busy_i` = 1, `hlda_o` stays 0 until a rising edge samples `cyc_end_i` = 1. It rises at that edge, and never during a cycle that has not signalled its end.
- R5: Whenever `hlda_o` = 1, both `bus_float_o` = 1 (drivers floated) and `ale_block_o` = 1 (address-latch strobe held low).
- R6: `stall_o` = 1 whenever the synchronized request is high, `hlda_o` is high, or `bus_float_o` is high.
- R7: After `hold_i` falls, `hlda_o` falls at the rising edge that follows the synchronized low, which is `SYNC_STAGES`+1 edges after the fall.
- R8: `bus_float_o` and `ale_block_o` stay at 1 for exactly `REARM_GAP` clocks after `hlda_o` falls, and then return to 0.
- R9: If the request is withdrawn while the block waits for a cycle to end, `hlda_o` never rises. The block returns to owning the bus with `stall_o` = 0 and `bus_float_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_i | input | 1 | Bus request from external master (asynchronous) |
| cyc_busy_i | input | 1 | A bus cycle is in progress |
| cyc_end_i | input | 1 | The current bus cycle ends this clock |
| hlda_o | output | 1 | Bus grant acknowledge to the external master |
| bus_float_o | output | 1 | Float the address, data and control drivers |
| ale_block_o | output | 1 | Force the address-latch strobe low |
| stall_o | output | 1 | Bus unit must not start a new cycle |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 and `REARM_GAP` = 2, which are wider than the defaults. With those values, the bench can tell a synchronizer stage that was added or dropped apart from the FSM's own one-clock step. It can also see a driver-off gap of more than one clock after release, so an off-by-one in the gap counter shows up. Because the bench derives every latency from these two parameters, the same directed scenarios also cover the default build.

// File: rtl/hold_pkg.sv
package hold_pkg;
  typedef enum logic [1:0] {
    ST_OWN    = 2'd0,
    ST_DRAIN  = 2'd1,
    ST_GRANT  = 2'd2,
    ST_RETURN = 2'd3
  } hold_state_e;
endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import hold_pkg::*;
#(
  parameter int REARM_GAP = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        hold_s_i,
  input  logic        cyc_busy_i,
  input  logic        cyc_end_i,
  output hold_state_e state_o
);
  localparam int CNT_W = (REARM_GAP > 1) ? $clog2(REARM_GAP) : 1;
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(REARM_GAP - 1);

  hold_state_e state_q, state_d;
  logic [CNT_W-1:0] gap_q, gap_d;
  logic bus_free;

  // bus is free if nothing runs or the running cycle ends now
  assign bus_free = !cyc_busy_i || cyc_end_i;

  always_comb begin
    state_d = state_q;
    gap_d   = gap_q;
    unique case (state_q)
      ST_OWN: begin
        if (hold_s_i) state_d = bus_free ? ST_GRANT : ST_DRAIN;
      end
      ST_DRAIN: begin
        if (!hold_s_i)     state_d = ST_OWN;
        else if (bus_free) state_d = ST_GRANT;
      end
      ST_GRANT: begin
        if (!hold_s_i) begin
          state_d = ST_RETURN;
          gap_d   = '0;
        end
      end
      ST_RETURN: begin
        if (gap_q == GAP_LAST) state_d = ST_OWN;
        else                   gap_d   = gap_q + 1'b1;
      end
      default: state_d = ST_OWN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OWN;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      gap_q   <= gap_d;
    end
  end

  assign state_o = state_q;

  a_r4_grant_at_cycle_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GRANT && $past(state_q) != ST_GRANT) |-> $past(!cyc_busy_i || cyc_end_i));
  a_r3_grant_needs_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GRANT && $past(state_q) != ST_GRANT) |-> $past(hold_s_i));
  a_r7_release_after_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RETURN && $past(state_q) == ST_GRANT) |-> $past(!hold_s_i));
endmodule

// File: rtl/hold_outputs.sv
module hold_outputs
  import hold_pkg::*;
(
  input  hold_state_e state_i,
  input  logic        hold_s_i,
  output logic        hlda_o,
  output logic        float_o,
  output logic        ale_block_o,
  output logic        stall_o
);
  always_comb begin
    hlda_o      = (state_i == ST_GRANT);
    float_o     = (state_i == ST_GRANT) || (state_i == ST_RETURN);
    ale_block_o = float_o;
    stall_o     = hold_s_i || (state_i != ST_OWN);
  end
endmodule

// File: rtl/bus_hold_arb.sv
module bus_hold_arb
  import hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REARM_GAP   = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic cyc_busy_i,
  input  logic cyc_end_i,
  output logic hlda_o,
  output logic bus_float_o,
  output logic ale_block_o,
  output logic stall_o
);
  logic        hold_s;
  hold_state_e state;

  hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (hold_i),
    .q_o    (hold_s)
  );

  hold_fsm #(.REARM_GAP(REARM_GAP)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_s_i   (hold_s),
    .cyc_busy_i (cyc_busy_i),
    .cyc_end_i  (cyc_end_i),
    .state_o    (state)
  );

  hold_outputs u_out (
    .state_i     (state),
    .hold_s_i    (hold_s),
    .hlda_o      (hlda_o),
    .float_o     (bus_float_o),
    .ale_block_o (ale_block_o),
    .stall_o     (stall_o)
  );

  a_r5_float_during_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (bus_float_o && ale_block_o));
  a_r8_no_overlap_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hlda_o) |-> bus_float_o);
  a_r6_stall_covers_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_float_o |-> stall_o);
endmodule

// File: tb/tb_bus_hold_arb.sv
module tb_bus_hold_arb;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 3;
  localparam int GAP  = 2;
  localparam int WATCHDOG_CYC = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold = 1'b0, busy = 1'b0, cend = 1'b0;
  logic hlda, flt, aleb, stall;
  int   errors = 0, checks = 0;
  int   hlda_rises = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_hold_arb #(.SYNC_STAGES(SYNC), .REARM_GAP(GAP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .hold_i(hold), .cyc_busy_i(busy),
    .cyc_end_i(cend), .hlda_o(hlda), .bus_float_o(flt),
    .ale_block_o(aleb), .stall_o(stall)
  );

  always @(posedge hlda) hlda_rises++;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    #(CLK_PERIOD/4);
    chk("R1 hlda in reset", hlda, 1'b0);
    chk("R1 float in reset", flt, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    edges(2);
    chk("R1 hlda after reset", hlda, 1'b0);
    chk("R1 float after reset", flt, 1'b0);
    chk("R1 ale after reset", aleb, 1'b0);
    chk("R1 stall after reset", stall, 1'b0);
  endtask

  task automatic t_idle_grant;
    hold = 1'b1;
    edges(SYNC-1);
    chk("R2 stall before sync", stall, 1'b0);
    chk("R2 hlda before sync", hlda, 1'b0);
    edges(1);
    chk("R2 stall after sync", stall, 1'b1);
    chk("R3 hlda not yet", hlda, 1'b0);
    edges(1);
    chk("R3 hlda idle grant", hlda, 1'b1);
    chk("R5 float in grant", flt, 1'b1);
    chk("R5 ale held low in grant", aleb, 1'b1);
    chk("R6 stall in grant", stall, 1'b1);
  endtask

  task automatic t_release;
    hold = 1'b0;
    edges(SYNC);
    chk("R7 hlda held until synced low seen", hlda, 1'b1);
    edges(1);
    chk("R7 hlda falls", hlda, 1'b0);
    chk("R8 float kept after fall", flt, 1'b1);
    chk("R6 stall during gap", stall, 1'b1);
    if (GAP > 1) begin
      edges(GAP-1);
      chk("R8 float through gap end", flt, 1'b1);
    end
    edges(1);
    chk("R8 float released", flt, 1'b0);
    chk("R8 ale released", aleb, 1'b0);
    chk("R6 stall released", stall, 1'b0);
  endtask

  task automatic t_drain_grant;
    busy = 1'b1;
    hold = 1'b1;
    edges(SYNC+1);
    chk("R4 no grant mid-cycle", hlda, 1'b0);
    chk("R4 no float mid-cycle", flt, 1'b0);
    chk("R6 stall while draining", stall, 1'b1);
    edges(3);
    chk("R4 still waiting", hlda, 1'b0);
    cend = 1'b1;
    edges(1);
    chk("R4 grant after cycle end", hlda, 1'b1);
    cend = 1'b0;
    busy = 1'b0;
    hold = 1'b0;
    edges(SYNC+1+GAP);
    chk("R8 float off after drain release", flt, 1'b0);
  endtask

  task automatic t_withdraw;
    int rises0;
    rises0 = hlda_rises;
    busy = 1'b1;
    hold = 1'b1;
    edges(SYNC+1);
    chk("R9 waiting stalls", stall, 1'b1);
    hold = 1'b0;
    edges(SYNC+1);
    chk("R9 stall cleared", stall, 1'b0);
    chk("R9 float clear", flt, 1'b0);
    chk("R9 hlda low", hlda, 1'b0);
    chk("R9 hlda never rose", (hlda_rises == rises0), 1'b1);
    busy = 1'b0;
    edges(1);
  endtask

  initial begin
    t_reset();
    t_idle_grant();
    t_release();
    t_drain_grant();
    t_withdraw();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule